// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block buffers 36-bit words between two clock domains. A producer pushes words on the rising edge of its own clock whenever its enable is high and the buffer is not full. A consumer pops them, oldest first, on the rising edge of a second clock. The two clocks are free-running. They may be unrelated, or they may be the very same net. On an edge where both ports are enabled, the write and the read both take effect.

Each side reports status in its own domain. The producer sees a full flag and an almost-full flag. The consumer sees an empty flag and an almost-empty flag. Each almost flag compares the fill level against a threshold held in a register on that side, and the threshold is loaded by a one-cycle parallel strobe. The read and write positions travel across the domain boundary only as Gray-coded values, each through a two-flop synchronizer. As a result, a flag reacts at once to its own port's traffic but reacts late to the other port's traffic.

Top module: `dual_clock_fifo`

## Requirements
- R1: The buffer holds 64 words of 36 bits. With no reads, the 64th accepted write raises `wr_full` on the write edge that accepts it.
- R2: A transfer happens only on a rising edge of its port clock with that port's enable high. Words leave in the order they entered.
- R3: When `wr_en` and `rd_en` are both high on an edge where the buffer is neither full nor empty, both transfers complete on that edge.
- R4: `wr_full` and `wr_afull` use a read position that has passed through two write-clock flops. When both ports share one clock, `wr_full` falls on the third write-clock edge after the edge that accepted a read. `rd_empty` falls on the third read-clock edge after the edge that accepted a write.
- R5: A write presented while `wr_full` is high is dropped. It does not change the stored data or the write position.
- R6: A read presented while `rd_empty` is high is dropped. `rd_data` holds its value and the read position does not move.
- R7: `wr_afull` is high when (write count minus synchronized read count) is at least 64 minus the almost-full threshold. A pulse on `af_off_load` replaces the threshold with `af_off_in`, and the new value is used from the following edge.
- R8: `rd_aempty` is high when (synchronized write count minus read count) is at most the almost-empty threshold. A pulse on `ae_off_load` replaces the threshold with `ae_off_in`, and the new value is used from the following edge.
- R9: Synchronous active-high reset has the following effects: both positions are cleared, `rd_empty` and `rd_aempty` are raised, `wr_full` and `wr_afull` are lowered, `rd_data` is set to 0, and both thresholds are set to 8.
- R10: `rd_data` is a register. It takes the popped word on the same read edge that accepts the read.
- R11: Each position value that crosses a domain changes by at most one bit per clock of the domain that drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous reset, write side |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to store |
| af_off_in | input | 6 | New almost-full threshold |
| af_off_load | input | 1 | Load strobe for the almost-full threshold |
| wr_full | output | 1 | Buffer full (write domain) |
| wr_afull | output | 1 | Almost full (write domain) |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous reset, read side |
| rd_en | input | 1 | Read request |
| ae_off_in | input | 6 | New almost-empty threshold |
| ae_off_load | input | 1 | Load strobe for the almost-empty threshold |
| rd_data | output | 36 | Popped word, registered |
| rd_empty | output | 1 | Buffer empty (read domain) |
| rd_aempty | output | 1 | Almost empty (read domain) |

## Verification
The bench drives both ports from a single 200 MHz clock, so every latency is a fixed number of edges.

Results from a port's own traffic are due on the accepting edge itself:
- `rd_data` takes the popped word on the read edge that accepts the read.
- `wr_full` and `wr_afull` respond on the write edge that accepts the write.
- `rd_empty` and `rd_aempty` respond on the read edge that accepts the read.

Traffic on the opposite port takes effect three edges later: one edge updates the position register, and two more carry it through the synchronizer. The reference model reproduces this by keeping a two-deep history of the opposite count. It steps on each rising edge, and the bench compares all four flags and `rd_data` at every falling edge, half a cycle after the values settle.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int DEF_DATA_W = 36;
  localparam int DEF_ADDR_W = 6;
  localparam int DEF_OFFSET = 8;
endpackage

// File: rtl/dcfifo_sync2.sv
module dcfifo_sync2 #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcfifo_gray_dec.sv
module dcfifo_gray_dec #(
  parameter int W = 7
) (
  input  logic [W-1:0] g,
  output logic [W-1:0] b
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b[i] = ^g[W-1:i];
  end
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= store[raddr];
  end

  // R6 / R10: output register moves only on an accepted read
  a_r10_hold_without_read: assert property (@(posedge rclk) disable iff (rrst)
    !re |=> $stable(rdata));
endmodule

// File: rtl/dcfifo_wr_ctrl.sv
module dcfifo_wr_ctrl #(
  parameter int AW      = 6,
  parameter int OFF_RST = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] off_in,
  input  logic          off_load,
  input  logic [AW:0]   rgray_s,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          afull
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin, wbin_nx, wgray_nx, rbin_s, fill_nx;
  logic [AW-1:0] off;
  logic          wr_ok;

  dcfifo_gray_dec #(.W(PW)) u_dec (.g(rgray_s), .b(rbin_s));

  assign wr_ok    = wr_en & ~full;
  assign wbin_nx  = wbin + PW'(wr_ok);
  assign wgray_nx = wbin_nx ^ (wbin_nx >> 1);
  assign fill_nx  = wbin_nx - rbin_s;
  assign mem_we   = wr_ok;
  assign mem_addr = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
      afull <= 1'b0;
      off   <= AW'(OFF_RST);
    end else begin
      wbin  <= wbin_nx;
      wgray <= wgray_nx;
      full  <= (wgray_nx == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
      afull <= (fill_nx >= (PW'(DEPTH) - {1'b0, off}));
      if (off_load) off <= off_in;
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> $stable(wbin));
  a_r7_full_implies_afull: assert property (@(posedge clk) disable iff (rst)
    full |-> afull);
  a_r11_wgray_one_step: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wgray ^ $past(wgray)));
  a_r9_wr_reset: assert property (@(posedge clk)
    rst |=> (!full && !afull && wgray == '0));
endmodule

// File: rtl/dcfifo_rd_ctrl.sv
module dcfifo_rd_ctrl #(
  parameter int AW      = 6,
  parameter int OFF_RST = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] off_in,
  input  logic          off_load,
  input  logic [AW:0]   wgray_s,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [AW:0]   rgray,
  output logic          empty,
  output logic          aempty
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin, rbin_nx, rgray_nx, wbin_s, fill_nx;
  logic [AW-1:0] off;
  logic          rd_ok;

  dcfifo_gray_dec #(.W(PW)) u_dec (.g(wgray_s), .b(wbin_s));

  assign rd_ok    = rd_en & ~empty;
  assign rbin_nx  = rbin + PW'(rd_ok);
  assign rgray_nx = rbin_nx ^ (rbin_nx >> 1);
  assign fill_nx  = wbin_s - rbin_nx;
  assign mem_re   = rd_ok;
  assign mem_addr = rbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin   <= '0;
      rgray  <= '0;
      empty  <= 1'b1;
      aempty <= 1'b1;
      off    <= AW'(OFF_RST);
    end else begin
      rbin   <= rbin_nx;
      rgray  <= rgray_nx;
      empty  <= (rgray_nx == wgray_s);
      aempty <= (fill_nx <= {1'b0, off});
      if (off_load) off <= off_in;
    end
  end

  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> $stable(rbin));
  a_r8_empty_implies_aempty: assert property (@(posedge clk) disable iff (rst)
    empty |-> aempty);
  a_r11_rgray_one_step: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rgray ^ $past(rgray)));
  a_r9_rd_reset: assert property (@(posedge clk)
    rst |=> (empty && aempty && rgray == '0));
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
  import dcfifo_pkg::*;
#(
  parameter int DATA_W  = DEF_DATA_W,
  parameter int ADDR_W  = DEF_ADDR_W,
  parameter int OFF_RST = DEF_OFFSET
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] af_off_in,
  input  logic              af_off_load,
  output logic              wr_full,
  output logic              wr_afull,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] ae_off_in,
  input  logic              ae_off_load,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic              rd_aempty
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic              mem_we, mem_re;
  logic [ADDR_W-1:0] waddr, raddr;

  dcfifo_wr_ctrl #(.AW(ADDR_W), .OFF_RST(OFF_RST)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .wr_en(wr_en),
    .off_in(af_off_in), .off_load(af_off_load), .rgray_s(rgray_s),
    .mem_we(mem_we), .mem_addr(waddr), .wgray(wgray),
    .full(wr_full), .afull(wr_afull)
  );

  dcfifo_rd_ctrl #(.AW(ADDR_W), .OFF_RST(OFF_RST)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en),
    .off_in(ae_off_in), .off_load(ae_off_load), .wgray_s(wgray_s),
    .mem_re(mem_re), .mem_addr(raddr), .rgray(rgray),
    .empty(rd_empty), .aempty(rd_aempty)
  );

  dcfifo_sync2 #(.W(PW)) u_sync_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s)
  );

  dcfifo_sync2 #(.W(PW)) u_sync_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s)
  );

  dcfifo_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .wclk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .rrst(rd_rst), .re(mem_re), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: tb/tb_dual_clock_fifo.sv
`timescale 1ns/1ps
module tb_dual_clock_fifo;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en, af_load, ae_load;
  logic [35:0] wr_data;
  logic [5:0]  af_in, ae_in;
  logic        wr_full, wr_afull, rd_empty, rd_aempty;
  logic [35:0] rd_data;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  dual_clock_fifo dut (
    .wr_clk(clk), .wr_rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .af_off_in(af_in), .af_off_load(af_load),
    .wr_full(wr_full), .wr_afull(wr_afull),
    .rd_clk(clk), .rd_rst(rst), .rd_en(rd_en),
    .ae_off_in(ae_in), .ae_off_load(ae_load),
    .rd_data(rd_data), .rd_empty(rd_empty), .rd_aempty(rd_aempty)
  );

  // behavioural reference
  logic [35:0] q[$];
  int  m_w, m_r, m_wq1, m_wq2, m_rq1, m_rq2, m_af, m_ae;
  bit  m_full, m_afull, m_empty, m_aempty;
  logic [35:0] m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_w = 0; m_r = 0; m_wq1 = 0; m_wq2 = 0; m_rq1 = 0; m_rq2 = 0;
      m_af = 8; m_ae = 8;
      m_full = 0; m_afull = 0; m_empty = 1; m_aempty = 1;
      m_rdata = '0;
    end else begin
      bit wok, rok;
      int nw, nr;
      wok = wr_en && !m_full;
      rok = rd_en && !m_empty;
      nw = (m_w + int'(wok)) & 127;
      nr = (m_r + int'(rok)) & 127;
      if (rok && q.size() > 0) m_rdata = q.pop_front();
      if (wok) q.push_back(wr_data);
      m_full   = (((nw - m_rq2) & 127) == 64);
      m_afull  = (((nw - m_rq2) & 127) >= 64 - m_af);
      m_empty  = (nr == m_wq2);
      m_aempty = (((m_wq2 - nr) & 127) <= m_ae);
      m_rq2 = m_rq1; m_rq1 = m_r;
      m_wq2 = m_wq1; m_wq1 = m_w;
      if (af_load) m_af = int'(af_in);
      if (ae_load) m_ae = int'(ae_in);
      m_w = nw; m_r = nr;
    end
  end

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: compare settled outputs at falling edge, then drive next inputs
  task automatic step(input bit we, input bit re);
    @(negedge clk);
    chk("R1/R4/R5 wr_full",   {35'd0, wr_full},   {35'd0, m_full});
    chk("R7 wr_afull",        {35'd0, wr_afull},  {35'd0, m_afull});
    chk("R4/R6 rd_empty",     {35'd0, rd_empty},  {35'd0, m_empty});
    chk("R8 rd_aempty",       {35'd0, rd_aempty}, {35'd0, m_aempty});
    chk("R2/R3/R10 rd_data",  rd_data,            m_rdata);
    wr_en   = we;
    rd_en   = re;
    wr_data = wr_data + 36'h1_0000_0101;
    af_load = 1'b0;
    ae_load = 1'b0;
  endtask

  task automatic run();
    rst = 1'b1; wr_en = 0; rd_en = 0; af_load = 0; ae_load = 0;
    af_in = '0; ae_in = '0; wr_data = 36'h0_0000_0001;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state at the ports
    chk("R9 reset wr_full",   {35'd0, wr_full},   36'd0);
    chk("R9 reset wr_afull",  {35'd0, wr_afull},  36'd0);
    chk("R9 reset rd_empty",  {35'd0, rd_empty},  36'd1);
    chk("R9 reset rd_aempty", {35'd0, rd_aempty}, 36'd1);
    chk("R9 reset rd_data",   rd_data,            36'd0);
    // R1, R5: fill past capacity, extra writes dropped
    repeat (70) step(1, 0);
    step(0, 0);
    chk("R1 full after 64 writes", {35'd0, wr_full}, 36'd1);
    // R2, R6: drain past empty, extra reads dropped
    repeat (72) step(0, 1);
    repeat (4) step(0, 0);
    chk("R6 empty after drain", {35'd0, rd_empty}, 36'd1);
    // R3: concurrent traffic after priming
    repeat (10) step(1, 0);
    repeat (5) step(0, 0);
    repeat (100) step(1, 1);
    repeat (80) step(0, 1);
    // R7, R8: new thresholds
    @(negedge clk);
    af_in = 6'd20; ae_in = 6'd3; af_load = 1'b1; ae_load = 1'b1;
    step(0, 0);
    repeat (70) step(1, 0);
    repeat (70) step(0, 1);
    af_in = 6'd0; ae_in = 6'd63; af_load = 1'b1; ae_load = 1'b1;
    step(0, 0);
    repeat (70) step(1, 0);
    repeat (70) step(0, 1);
    // R4 etc.: random mixes with write bias then read bias
    for (int i = 0; i < 3000; i++) begin
      bit we, re;
      we = ($urandom % 4) != 0;
      re = ($urandom % 4) == 0;
      if (i >= 1500) begin we = !we; re = !re; end
      if (i % 500 == 7) begin
        af_in = 6'($urandom); ae_in = 6'($urandom);
        af_load = 1'b1; ae_load = 1'b1;
      end
      step(we, re);
    end
    repeat (20) step(($urandom % 2) == 1, ($urandom % 2) == 1);
    // R11 is covered by the gray-step assertions in the RTL
  endtask

  initial begin
    fork
      run();
      begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule